// File: doc/BRIEF.md
# CPU Condition Code Flag Unit

This block holds the eight-bit condition code byte of a small accumulator CPU and produces the flag updates that arithmetic and logic operations cause. Each cycle in which `op_valid` is high, it combines the accumulator operand with the memory operand according to `op_sel`. On the next clock edge it registers the eight-bit result and the affected flags. The block takes one operation every cycle and never stalls, so it has no ready signal. An operation presented with `op_valid` low is dropped, and there is no back-pressure to honour.

The interrupt mask flag has its own control path. The interrupt sequencer pulses `int_entry` at the single point of entry where the register save has finished and the vector fetch has not yet started, and the mask is set on that clock edge. Software-style requests can set or clear the mask. A whole byte can be written into the flags, for example when flags are restored on return from interrupt. `irq_enable` tells the interrupt controller whether maskable requests may be taken.

Top module: `ccr_unit`

## Requirements
- R1: `ccr_out` bit order, from bit 7 down to bit 0, is V, 1, 1, H, I, N, Z, C. Bits 6 and 5 always read 1, even after a byte load that writes 0 into them.
- R2: `op_sel` encodes the operations as follows: 0 add, 1 add with carry, 2 subtract (acc minus mem), 3 AND, 4 OR, 5 XOR, 6 load (result = mem), 7 test (result = acc). `result_out` holds the result one clock edge after `op_valid`.
- R3: V is set when the add, add-with-carry or subtract overflows in two's complement, and cleared otherwise. The four logical, load and test operations clear V.
- R4: H is the carry from bit 3 into bit 4, including the incoming C for add with carry. Only add and add with carry update H. Every other operation leaves it unchanged.
- R5: N equals bit 7 of the result. Z is 1 exactly when all eight result bits are zero. Every accepted operation updates both.
- R6: C is the carry out of bit 7 for add and add with carry (which adds the incoming C), and the borrow (acc < mem, unsigned) for subtract. The logical, load and test operations leave C unchanged.
- R7: The I flag (bit 3) is 1 at the edge after `int_entry`. The I flag follows this priority: `int_entry` wins, then `ccr_load` (which takes `ccr_din` bit 3), then `mask_set`, then `mask_clr`.
- R8: `irq_enable` is the inverse of I and changes on the same clock edge as I.
- R9: After reset, `ccr_out` is 8'h68 (I = 1, the other flags 0), `irq_enable` is 0 and `result_out` is 0.
- R10: `ccr_load` writes V, H, N, Z and C from `ccr_din`, taking priority over an operation in the same cycle. The result register still captures that operation.
- R11: With `op_valid` low, the operands and `op_sel` change neither `result_out` nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Operation code (see R2) |
| acc_in | input | 8 | Accumulator operand |
| mem_in | input | 8 | Memory operand |
| int_entry | input | 1 | Interrupt entry point: save done, vector fetch not begun |
| mask_set | input | 1 | Request to set the interrupt mask |
| mask_clr | input | 1 | Request to clear the interrupt mask |
| ccr_load | input | 1 | Load the flag byte from `ccr_din` |
| ccr_din | input | 8 | Byte to load into the flags |
| ccr_out | output | 8 | Condition code byte |
| result_out | output | 8 | Registered operation result |
| irq_enable | output | 1 | Maskable interrupts allowed |

## Verification
Every flag is a single register bit that `ccr_out` presents directly. A wrong update therefore appears one edge after the operation that caused it, and the next operation does not mask it. This holds because H and C keep their value through operations that do not own them: a stale or spurious update stays visible until an add or a byte load overwrites it. Errors in the mask path appear on both `ccr_out` bit 3 and `irq_enable` at the edge after the request, so a disagreement between the two is also caught at once. The bench checks the add operation exhaustively over all operand pairs, and the subtract and add-with-carry operations over dense grids, each with a flag model the bench computes itself.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_LOAD = 3'd6,
    OP_TEST = 3'd7
  } op_e;

  localparam int CCR_W = 8;
  localparam int POS_C = 0;
  localparam int POS_Z = 1;
  localparam int POS_N = 2;
  localparam int POS_I = 3;
  localparam int POS_H = 4;
  localparam int POS_V = 7;
  localparam logic [CCR_W-1:0] ONES_MASK = 8'b0110_0000;

  typedef struct packed {
    logic v;
    logic h;
    logic n;
    logic z;
    logic c;
  } aflags_t;
endpackage

// File: rtl/ccr_alu.sv
module ccr_alu
  import ccr_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e            op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   m,
  input  logic           cin,
  output logic [W-1:0]   res,
  output aflags_t        fl,
  output logic           h_own,
  output logic           c_own
);
  localparam int HB = W / 2;

  logic [W:0]  wide;
  logic [HB:0] low;
  logic        ci;

  always_comb begin
    ci    = (op == OP_ADC) ? cin : 1'b0;
    wide  = '0;
    low   = '0;
    res   = '0;
    fl    = '0;
    h_own = 1'b0;
    c_own = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        wide  = {1'b0, a} + {1'b0, m} + {{W{1'b0}}, ci};
        low   = {1'b0, a[HB-1:0]} + {1'b0, m[HB-1:0]} + {{HB{1'b0}}, ci};
        res   = wide[W-1:0];
        fl.c  = wide[W];
        fl.h  = low[HB];
        fl.v  = (a[W-1] == m[W-1]) && (res[W-1] != a[W-1]);
        h_own = 1'b1;
        c_own = 1'b1;
      end
      OP_SUB: begin
        wide  = {1'b0, a} - {1'b0, m};
        res   = wide[W-1:0];
        fl.c  = wide[W];
        fl.v  = (a[W-1] != m[W-1]) && (res[W-1] != a[W-1]);
        c_own = 1'b1;
      end
      OP_AND:  res = a & m;
      OP_OR:   res = a | m;
      OP_XOR:  res = a ^ m;
      OP_LOAD: res = m;
      OP_TEST: res = a;
      default: res = '0;
    endcase
    fl.n = res[W-1];
    fl.z = ~|res;
  end
endmodule

// File: rtl/ccr_arith_flags.sv
module ccr_arith_flags
  import ccr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    upd,
  input  logic    ld,
  input  aflags_t ld_val,
  input  aflags_t alu_fl,
  input  logic    h_own,
  input  logic    c_own,
  input  logic    op_is_logic,
  output aflags_t q
);
  aflags_t d;

  always_comb begin
    d = q;
    if (ld) begin
      d = ld_val;
    end else if (upd) begin
      d.v = alu_fl.v;
      d.n = alu_fl.n;
      d.z = alu_fl.z;
      if (h_own) d.h = alu_fl.h;
      if (c_own) d.c = alu_fl.c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R4: H survives any non-add operation
  a_r4_h_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ld && !h_own) |=> $stable(q.h));

  // R6: C survives logical/load/test
  a_r6_c_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ld && !c_own) |=> $stable(q.c));

  // R3: logical group clears V
  a_r3_logic_clears_v: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ld && op_is_logic) |=> !q.v);

  // R11: no request leaves every flag in place
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !ld) |=> $stable(q));
endmodule

// File: rtl/ccr_mask.sv
module ccr_mask (
  input  logic clk,
  input  logic rst_n,
  input  logic int_entry,
  input  logic ld,
  input  logic ld_i,
  input  logic set_req,
  input  logic clr_req,
  output logic i_q,
  output logic en_q
);
  logic i_d;

  always_comb begin
    i_d = i_q;
    if (int_entry)    i_d = 1'b1;
    else if (ld)      i_d = ld_i;
    else if (set_req) i_d = 1'b1;
    else if (clr_req) i_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q  <= 1'b1;
      en_q <= 1'b0;
    end else begin
      i_q  <= i_d;
      en_q <= ~i_d;
    end
  end

  // R7: interrupt entry forces the mask on the next edge
  a_r7_entry_masks: assert property (@(posedge clk) disable iff (!rst_n)
    int_entry |=> i_q);

  // R7: a clear request alone opens the mask
  a_r7_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req && !ld && !int_entry) |=> !i_q);

  // R8: enable is always the complement of the mask
  a_r8_enable_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == !i_q);
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [2:0] op_sel,
  input  logic [7:0] acc_in,
  input  logic [7:0] mem_in,
  input  logic       int_entry,
  input  logic       mask_set,
  input  logic       mask_clr,
  input  logic       ccr_load,
  input  logic [7:0] ccr_din,
  output logic [7:0] ccr_out,
  output logic [7:0] result_out,
  output logic       irq_enable
);
  op_e          op;
  logic [7:0]   alu_res;
  aflags_t      alu_fl;
  aflags_t      fl_q;
  aflags_t      ld_val;
  logic         h_own;
  logic         c_own;
  logic         op_is_logic;
  logic         i_q;
  logic [7:0]   res_q;

  assign op          = op_e'(op_sel);
  assign op_is_logic = !(h_own || c_own);
  assign ld_val      = '{v: ccr_din[POS_V], h: ccr_din[POS_H], n: ccr_din[POS_N],
                         z: ccr_din[POS_Z], c: ccr_din[POS_C]};

  ccr_alu #(.W(CCR_W)) u_alu (
    .op    (op),
    .a     (acc_in),
    .m     (mem_in),
    .cin   (fl_q.c),
    .res   (alu_res),
    .fl    (alu_fl),
    .h_own (h_own),
    .c_own (c_own)
  );

  ccr_arith_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd         (op_valid),
    .ld          (ccr_load),
    .ld_val      (ld_val),
    .alu_fl      (alu_fl),
    .h_own       (h_own),
    .c_own       (c_own),
    .op_is_logic (op_is_logic),
    .q           (fl_q)
  );

  ccr_mask u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_entry (int_entry),
    .ld        (ccr_load),
    .ld_i      (ccr_din[POS_I]),
    .set_req   (mask_set),
    .clr_req   (mask_clr),
    .i_q       (i_q),
    .en_q      (irq_enable)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (op_valid) res_q <= alu_res;
  end

  assign result_out = res_q;

  genvar b;
  for (b = 0; b < CCR_W; b++) begin : g_byte
    if (ONES_MASK[b]) begin : g_one
      assign ccr_out[b] = 1'b1;
    end else if (b == POS_V) begin : g_v
      assign ccr_out[b] = fl_q.v;
    end else if (b == POS_H) begin : g_h
      assign ccr_out[b] = fl_q.h;
    end else if (b == POS_I) begin : g_i
      assign ccr_out[b] = i_q;
    end else if (b == POS_N) begin : g_n
      assign ccr_out[b] = fl_q.n;
    end else if (b == POS_Z) begin : g_z
      assign ccr_out[b] = fl_q.z;
    end else begin : g_c
      assign ccr_out[b] = fl_q.c;
    end
  end

  // R5: Z and N agree with the registered result after an accepted operation
  a_r5_zn_track: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ccr_load) |=> (ccr_out[POS_Z] == (result_out == 8'h00))
                                && (ccr_out[POS_N] == result_out[7]));

  // R2: result register captures only accepted operations
  a_r2_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(result_out));
endmodule

// File: tb/ccr_unit_test.sv
`timescale 1ns/1ps
module ccr_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] mem_in = 8'h00;
  logic       int_entry = 1'b0;
  logic       mask_set = 1'b0;
  logic       mask_clr = 1'b0;
  logic       ccr_load = 1'b0;
  logic [7:0] ccr_din = 8'h00;
  logic [7:0] ccr_out;
  logic [7:0] result_out;
  logic       irq_enable;

  int checks = 0;
  int errors = 0;

  logic mv, mh, mi, mn, mz, mc;
  logic [7:0] mres;

  always #4 clk = ~clk;

  ccr_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .acc_in(acc_in), .mem_in(mem_in), .int_entry(int_entry),
    .mask_set(mask_set), .mask_clr(mask_clr), .ccr_load(ccr_load),
    .ccr_din(ccr_din), .ccr_out(ccr_out), .result_out(result_out),
    .irq_enable(irq_enable)
  );

  function automatic logic [7:0] exp_ccr();
    return {mv, 1'b1, 1'b1, mh, mi, mn, mz, mc};
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_op(input int op, input int a, input int m);
    int ci, s, sa, sm, sv;
    ci = (op == 1) ? int'(mc) : 0;
    sa = (a > 127) ? a - 256 : a;
    sm = (m > 127) ? m - 256 : m;
    case (op)
      0, 1: begin
        s    = a + m + ci;
        mres = s[7:0];
        mc   = (s > 255);
        mh   = (((a % 16) + (m % 16) + ci) > 15);
        sv   = sa + sm + ci;
        mv   = (sv > 127) || (sv < -128);
      end
      2: begin
        s    = a - m;
        mres = s[7:0];
        mc   = (a < m);
        sv   = sa - sm;
        mv   = (sv > 127) || (sv < -128);
      end
      3: begin mres = 8'(a) & 8'(m); mv = 1'b0; end
      4: begin mres = 8'(a) | 8'(m); mv = 1'b0; end
      5: begin mres = 8'(a) ^ 8'(m); mv = 1'b0; end
      6: begin mres = 8'(m); mv = 1'b0; end
      default: begin mres = 8'(a); mv = 1'b0; end
    endcase
    mn = mres[7];
    mz = (mres == 8'h00);
  endtask

  task automatic do_op(input int op, input int a, input int m, input string tag);
    op_sel   = 3'(op);
    acc_in   = 8'(a);
    mem_in   = 8'(m);
    op_valid = 1'b1;
    model_op(op, a, m);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check8({tag, " result"}, result_out, mres);
    check8({tag, " flags"}, ccr_out, exp_ccr());
  endtask

  task automatic do_load(input logic [7:0] d);
    ccr_load = 1'b1;
    ccr_din  = d;
    {mv, mh, mi, mn, mz, mc} = {d[7], d[4], d[3], d[2], d[1], d[0]};
    @(posedge clk);
    @(negedge clk);
    ccr_load = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    {mv, mh, mn, mz, mc} = '0;
    mi = 1'b1;
    mres = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check8("R9 reset ccr", ccr_out, 8'h68);
    check8("R9 reset result", result_out, 8'h00);
    check8("R9 reset irq_enable", {7'd0, irq_enable}, 8'h00);

    // R1 fixed ones survive a zero load, full byte load
    do_load(8'h00);
    check8("R1 zero load", ccr_out, 8'h60);
    do_load(8'hFF);
    check8("R1 ones load", ccr_out, 8'hFF);
    do_load(8'h00);

    // R2 R3 R4 R5 R6 exhaustive add
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m++)
        do_op(0, a, m, "R3 R4 R5 R6 add");

    // R6 R3 subtract grid
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m += 5)
        do_op(2, a, m, "R6 R3 R4 sub");

    // R4 R6 add with carry, both carry-in values
    for (int cin = 0; cin < 2; cin++)
      for (int a = 0; a < 256; a += 9)
        for (int m = 0; m < 256; m += 7) begin
          do_load(cin != 0 ? 8'h11 : 8'h00);
          do_op(1, a, m, "R4 R6 adc");
        end

    // R2 R3 R4 R6 logical, load, test keep H and C
    for (int op = 3; op < 8; op++)
      for (int a = 0; a < 256; a += 17)
        for (int m = 0; m < 256; m += 15) begin
          do_load(8'h93);
          do_op(op, a, m, "R2 R3 R4 R6 logic");
        end

    // R11 operands without op_valid
    do_op(0, 8'h12, 8'h34, "R11 setup");
    op_sel = 3'd2; acc_in = 8'h00; mem_in = 8'h80;
    @(posedge clk); @(negedge clk);
    check8("R11 idle result", result_out, 8'h46);
    check8("R11 idle flags", ccr_out, exp_ccr());

    // R10 load wins over a same-cycle operation
    op_sel = 3'd0; acc_in = 8'hFF; mem_in = 8'h01; op_valid = 1'b1;
    ccr_load = 1'b1; ccr_din = 8'h85;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0; ccr_load = 1'b0;
    {mv, mh, mi, mn, mz, mc} = {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    check8("R10 load priority flags", ccr_out, exp_ccr());
    check8("R10 result still captured", result_out, 8'h00);

    // R7 R8 mask control
    mask_set = 1'b1;
    @(posedge clk); @(negedge clk);
    mask_set = 1'b0;
    check8("R7 set", {ccr_out[3], irq_enable}, 8'h02);
    mask_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    mask_clr = 1'b0;
    check8("R7 R8 clear", {ccr_out[3], irq_enable}, 8'h01);
    int_entry = 1'b1; mask_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    int_entry = 1'b0; mask_clr = 1'b0;
    check8("R7 R8 entry beats clear", {ccr_out[3], irq_enable}, 8'h02);
    ccr_load = 1'b1; ccr_din = 8'h00; mask_set = 1'b1;
    @(posedge clk); @(negedge clk);
    ccr_load = 1'b0; mask_set = 1'b0;
    check8("R7 load beats set", {ccr_out[3], irq_enable}, 8'h01);
    int_entry = 1'b1; ccr_load = 1'b1; ccr_din = 8'h00;
    @(posedge clk); @(negedge clk);
    int_entry = 1'b0; ccr_load = 1'b0;
    check8("R7 entry beats load", {ccr_out[3], irq_enable}, 8'h02);
    mask_set = 1'b1; mask_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    mask_set = 1'b0; mask_clr = 1'b0;
    check8("R7 set beats clear", {ccr_out[3], irq_enable}, 8'h02);

    // R9 reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check8("R9 second reset", ccr_out, 8'h68);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule